// File: doc/BRIEF.md
# I2C Bus-Busy and Arbitration Monitor

This block sits beside a single-master I2C controller and watches the raw SCL and SDA pins. Both lines pass through a two-stage synchroniser and then a glitch filter whose length can be set at run time. A new level is accepted only after it has held for `flt_len + 1` system clocks. The filtered lines drive START and STOP detection and a bus-busy status. That status rises on a START and falls only on a STOP. Lines that return to idle-high by any other path leave it set. A frame that is cut short without a STOP therefore shows up as a busy bus that stays busy.

While the local master is sending, the monitor compares each bit the master means to put on the bus with SDA as sampled at the rising edge of SCL. The master releases SDA for a 1. If SDA is sampled low at that point, the monitor sets a sticky arbitration-lost flag and asserts a release output. That output tells the master to let go of both lines at once, without a STOP. Only an explicit clear from software drops the flag. During the acknowledge bit the monitor records the sampled SDA level as a received-no-acknowledge status and does not compare it for arbitration.

Top module: `i2c_bus_watch`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `busy`, `arb_lost`, `rx_nack` and `bus_release` to 0 and treats both lines as idle-high. This holds even when the bus was busy before the reset.
- R2: A START sets `busy` to 1. A START is a falling edge of filtered SDA while filtered SCL is high.
- R3: A STOP clears `busy` to 0. A STOP is a rising edge of filtered SDA while filtered SCL is high.
- R4: `busy` is cleared by a STOP or a reset and by nothing else. When SDA rises while SCL is low and SCL then rises, both lines end high but `busy` stays 1.
- R5: A level change on SCL or SDA that lasts fewer than `flt_len + 1` clock cycles is ignored. For example, with `flt_len` = 4, a 3-cycle low pulse on SDA while SCL is high does not set `busy`.
- R6: When SDA falls with SCL high and stays low, `busy` goes to 1 on exactly the (`flt_len` + 4)th rising clock edge that samples the new level, and not earlier.
- R7: Arbitration is lost when all of the following hold at a rising edge of filtered SCL: `mst_active` = 1, `ack_phase` = 0, `tx_bit` = 1 and filtered SDA = 0. `arb_lost` then becomes 1 and `bus_release` becomes 1.
- R8: Once set, `arb_lost` stays 1, also through a later STOP, until a cycle with `arb_clr` = 1 and no new loss. Such a cycle returns it to 0.
- R9: A bit where SDA matches `tx_bit` (both 1, or both 0) does not set `arb_lost`. A low SDA during an `ack_phase` bit does not set `arb_lost` either.
- R10: At a rising edge of SCL with `mst_active` = 1 and `ack_phase` = 1, `rx_nack` takes the SDA level (1 = no acknowledge, 0 = acknowledge). A NACK leaves `busy` unchanged at 1.
- R11: With `mst_active` = 0, a released `tx_bit` that samples SDA low does not set `arb_lost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| flt_len | input | FW | Glitch filter length in clocks (a change must hold flt_len+1 clocks) |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| mst_active | input | 1 | Local master is sending on the bus |
| tx_bit | input | 1 | Level the master drives for the current bit (1 = released) |
| ack_phase | input | 1 | Current bit is the acknowledge (ninth) bit |
| arb_clr | input | 1 | Software clear of the arbitration-lost flag |
| busy | output | 1 | Bus-busy status |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| rx_nack | output | 1 | Last acknowledge bit was a NACK |
| bus_release | output | 1 | Master must release SCL and SDA immediately |
| start_det | output | 1 | One-cycle pulse on a filtered START |
| stop_det | output | 1 | One-cycle pulse on a filtered STOP |

## Verification
Assertions check on every cycle that a START is always followed by `busy` and that a STOP always clears it. They also check that `busy` never falls except after a STOP or a reset. For the flags, they check that `arb_lost` never drops without a clear and rises only during a non-acknowledge bit driven as released by an active master. Finally, they check that `rx_nack` changes only on acknowledge bits.

Other behaviour can only be shown by the bench scenarios driving real line sequences. These cover the exact filter latency and the rejection of short glitches. They also cover the stuck-busy case where the lines return high without a STOP, and a flag surviving a STOP. The last group is the bit patterns that must not count as a mismatch: matching bits, the acknowledge slot and an idle master.

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] flt_len,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          mst_active,
  input  logic          tx_bit,
  input  logic          ack_phase,
  input  logic          arb_clr,
  output logic          busy,
  output logic          arb_lost,
  output logic          rx_nack,
  output logic          bus_release,
  output logic          start_det,
  output logic          stop_det
);

  localparam int NL = 2;

  logic [NL-1:0] meta, syn, filt, prev;
  logic [FW-1:0] cnt [NL];

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '1;
      syn  <= '1;
      prev <= '1;
    end else begin
      meta <= {scl_in, sda_in};
      syn  <= meta;
      prev <= filt;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NL; i++) begin
      if (rst) begin
        filt[i] <= 1'b1;
        cnt[i]  <= '0;
      end else if (syn[i] == filt[i]) begin
        cnt[i] <= '0;
      end else if (cnt[i] >= flt_len) begin
        filt[i] <= syn[i];
        cnt[i]  <= '0;
      end else begin
        cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  logic scl, sda, scl_q, sda_q, scl_rise, mismatch;

  assign scl   = filt[1];
  assign sda   = filt[0];
  assign scl_q = prev[1];
  assign sda_q = prev[0];

  assign scl_rise  = scl & ~scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
  assign mismatch  = mst_active & ~ack_phase & scl_rise & tx_bit & ~sda;

  always_ff @(posedge clk) begin
    if (rst)            busy <= 1'b0;
    else if (start_det) busy <= 1'b1;
    else if (stop_det)  busy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)           arb_lost <= 1'b0;
    else if (mismatch) arb_lost <= 1'b1;
    else if (arb_clr)  arb_lost <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                                    rx_nack <= 1'b0;
    else if (mst_active && ack_phase && scl_rise) rx_nack <= sda;
  end

  assign bus_release = arb_lost;

  // R2
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> busy);

  // R3
  busy_clr_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !busy);

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(stop_det) || $past(rst)));

  // R8
  arb_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (arb_lost && !arb_clr) |=> arb_lost);

  // R7
  arb_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> $past(mst_active && !ack_phase && tx_bit));

  // R10
  nack_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_nack) |-> ($past(mst_active && ack_phase) || $past(rst)));

endmodule

// File: tb/test_i2c_bus_watch.sv
module test_i2c_bus_watch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] flt_len = 4'd0;
  logic       scl_in = 1'b1, sda_in = 1'b1;
  logic       mst_active = 1'b0, tx_bit = 1'b1, ack_phase = 1'b0, arb_clr = 1'b0;
  logic       busy, arb_lost, rx_nack, bus_release, start_det, stop_det;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_bus_watch #(.FW(4)) i_i2c_bus_watch (
    .clk(clk), .rst(rst), .flt_len(flt_len), .scl_in(scl_in), .sda_in(sda_in),
    .mst_active(mst_active), .tx_bit(tx_bit), .ack_phase(ack_phase), .arb_clr(arb_clr),
    .busy(busy), .arb_lost(arb_lost), .rx_nack(rx_nack), .bus_release(bus_release),
    .start_det(start_det), .stop_det(stop_det));

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic line(logic c, logic d);
    scl_in = c;
    sda_in = d;
    tick(10);
  endtask

  task automatic gen_start();
    line(1, 1);
    line(1, 0);
    line(0, 0);
  endtask

  task automatic gen_stop();
    line(0, 0);
    line(1, 0);
    line(1, 1);
  endtask

  task automatic bit_cycle(logic txb, logic level, logic ack);
    scl_in = 0;
    tick(6);
    tx_bit = txb;
    ack_phase = ack;
    sda_in = level;
    tick(6);
    scl_in = 1;
    tick(10);
    scl_in = 0;
    tick(6);
    ack_phase = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    tick(3);
    rst = 0;
    tick(2);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 busy after reset", busy, 0);
    chk("R1 arb_lost after reset", arb_lost, 0);
    chk("R1 rx_nack after reset", rx_nack, 0);
    chk("R1 bus_release after reset", bus_release, 0);
    gen_start();
    chk("R2 busy before mid-run reset", busy, 1);
    scl_in = 1; sda_in = 1;
    do_reset();
    chk("R1 reset clears busy", busy, 0);
  endtask

  task automatic t_latency(logic [3:0] l);
    flt_len = l;
    line(1, 1);
    tick(20);
    sda_in = 0;
    tick(int'(l) + 3);
    chk("R6 busy not yet set", busy, 0);
    tick(1);
    chk("R6 busy set on exact edge", busy, 1);
    chk("R2 START sets busy", busy, 1);
    gen_stop();
    tick(20);
    chk("R3 STOP clears busy", busy, 0);
    flt_len = 0;
  endtask

  task automatic t_no_stop();
    gen_start();
    line(0, 1);
    line(1, 1);
    tick(30);
    chk("R4 idle-high without STOP keeps busy", busy, 1);
    gen_stop();
    chk("R3 later STOP clears busy", busy, 0);
  endtask

  task automatic t_glitch();
    flt_len = 4;
    line(1, 1);
    tick(20);
    sda_in = 0;
    tick(3);
    sda_in = 1;
    tick(30);
    chk("R5 short SDA glitch ignored", busy, 0);
    flt_len = 0;
  endtask

  task automatic t_arb();
    gen_start();
    mst_active = 1;
    bit_cycle(1, 1, 0);
    chk("R9 matching 1 no loss", arb_lost, 0);
    bit_cycle(0, 0, 0);
    chk("R9 matching 0 no loss", arb_lost, 0);
    bit_cycle(1, 0, 1);
    chk("R9 low ack bit no loss", arb_lost, 0);
    bit_cycle(1, 0, 0);
    chk("R7 mismatch sets arb_lost", arb_lost, 1);
    chk("R7 mismatch sets bus_release", bus_release, 1);
    mst_active = 0;
    gen_stop();
    chk("R8 arb_lost survives STOP", arb_lost, 1);
    chk("R3 busy cleared by STOP", busy, 0);
    arb_clr = 1;
    tick(1);
    arb_clr = 0;
    tick(1);
    chk("R8 arb_clr clears arb_lost", arb_lost, 0);
    chk("R8 bus_release dropped", bus_release, 0);
  endtask

  task automatic t_ack();
    gen_start();
    mst_active = 1;
    bit_cycle(1, 1, 1);
    chk("R10 NACK sets rx_nack", rx_nack, 1);
    chk("R10 busy held after NACK", busy, 1);
    bit_cycle(1, 0, 1);
    chk("R10 ACK clears rx_nack", rx_nack, 0);
    mst_active = 0;
    gen_stop();
  endtask

  task automatic t_idle_master();
    gen_start();
    mst_active = 0;
    bit_cycle(1, 0, 0);
    chk("R11 inactive master no loss", arb_lost, 0);
    gen_stop();
  endtask

  initial begin
    t_reset();
    t_latency(4'd0);
    t_latency(4'd3);
    t_no_stop();
    t_glitch();
    t_arb();
    t_ack();
    t_idle_master();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule